// File: doc/BRIEF.md
# Multiplexed Register-File Datapath

This block is the data path of a general-register processor. A 14-bit control word arrives every clock. It names two operand sources, an ALU function and a destination. Each operand source can be one of seven working registers or the external input bus. The ALU combines the two selected operands. The result goes out on the output bus in the same cycle. When a destination is named, the result is also captured into that register on the next rising clock edge.

A sequencer outside the block supplies the control words. It can build a register transfer such as "R3 takes R1 minus R2" as one word. It can also move the input bus straight to the output bus without disturbing any register. Operand reads are combinational, and the register file has one write port.

Top module: `rfd_datapath`

## Requirements
- R1: While `rst_n` is low, all seven registers are cleared to zero, and they read back as zero once reset is released.
- R2: The control word bit fields are: operand A select in [13:11], operand B select in [10:8], destination select in [7:5] and ALU function in [4:0].
- R3: Source select code 0 places `data_in` on the operand. Codes 1 to 7 place registers R1 to R7 on the operand. This holds for both operand A and operand B.
- R4: Destination code 0 leaves every register unchanged. Code k from 1 to 7 loads the ALU result into Rk only, and all other registers keep their values.
- R5: The arithmetic function codes are 00010 for A+B, 00101 for A−B (formed as A plus the two's complement of B), 00001 for A+1 and 00110 for A−1. All results wrap modulo 2^W.
- R6: The logic function codes are 01000 for AND, 01010 for OR, 01100 for XOR, 01110 for the complement of A and 00000 for a pass of A.
- R7: Function code 10000 shifts A right by one place and keeps the sign bit. Code 10001 shifts A left by one place and fills with zero.
- R8: Any function code not listed in R5 to R7 produces zero. If a destination is named, that zero is written to it.
- R9: `result_out` shows the ALU result every cycle, whatever the destination code is.
- R10: The write takes effect at the rising edge that ends the cycle. Within the cycle, a register named both as a source and as the destination supplies its old value. The new value is seen by the source selects from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write happens on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Control word: A select, B select, destination, function |
| data_in | input | W (8) | External operand bus, chosen by source code 0 |
| result_out | output | W (8) | ALU result, present every cycle |

## Verification
A single control word can read a register and write the same register. For example, XOR of R2 with itself into R2 reads and writes R2 at once, and a chain of increments on R6 does the same. The bench checks that the output in that cycle is built from the old contents. It then checks that the next word sees the updated value. A second overlap is tested as well: a word drives the input bus through to the output while naming no destination. The bench checks the output value, then reads all seven registers back to confirm that none of them changed.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  localparam int SEL_W  = 3;
  localparam int FUNC_W = 5;
  localparam int CW_W   = 3 * SEL_W + FUNC_W;
  localparam int NREG   = (1 << SEL_W) - 1;

  typedef enum logic [FUNC_W-1:0] {
    FN_PASS = 5'b00000,
    FN_INC  = 5'b00001,
    FN_ADD  = 5'b00010,
    FN_SUB  = 5'b00101,
    FN_DEC  = 5'b00110,
    FN_AND  = 5'b01000,
    FN_OR   = 5'b01010,
    FN_XOR  = 5'b01100,
    FN_NOT  = 5'b01110,
    FN_SHRA = 5'b10000,
    FN_SHL  = 5'b10001
  } func_e;

  typedef struct packed {
    logic [SEL_W-1:0]  src_a;
    logic [SEL_W-1:0]  src_b;
    logic [SEL_W-1:0]  dst;
    logic [FUNC_W-1:0] func;
  } ctrl_t;
endpackage

// File: rtl/rfd_regfile.sv
module rfd_regfile
  import rfd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SEL_W-1:0]         dst,
  input  logic [W-1:0]             wdata,
  output logic [NREG-1:0][W-1:0]   reg_q
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic           wen;
    logic [W-1:0]   nxt;

    always_comb begin
      wen = (dst == SEL_W'(k + 1));
      nxt = wen ? wdata : reg_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[k] <= '0;
      end else if (wen) begin
        reg_q[k] <= nxt;
      end
    end
  end
endmodule

// File: rtl/rfd_srcmux.sv
module rfd_srcmux
  import rfd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [W-1:0]             ext,
  input  logic [NREG-1:0][W-1:0]   regs,
  output logic [W-1:0]             operand
);
  always_comb begin
    if (sel == '0) begin
      operand = ext;
    end else begin
      operand = regs[sel - SEL_W'(1)];
    end
  end
endmodule

// File: rtl/rfd_alu.sv
module rfd_alu
  import rfd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  output logic [W-1:0]      res
);
  logic [W-1:0] sum_ab;
  logic [W-1:0] diff_ab;

  always_comb begin
    sum_ab  = op_a + op_b;
    diff_ab = op_a + (~op_b) + W'(1);
  end

  always_comb begin
    case (func)
      FN_PASS: res = op_a;
      FN_INC:  res = op_a + W'(1);
      FN_ADD:  res = sum_ab;
      FN_SUB:  res = diff_ab;
      FN_DEC:  res = op_a - W'(1);
      FN_AND:  res = op_a & op_b;
      FN_OR:   res = op_a | op_b;
      FN_XOR:  res = op_a ^ op_b;
      FN_NOT:  res = ~op_a;
      FN_SHRA: res = {op_a[W-1], op_a[W-1:1]};
      FN_SHL:  res = {op_a[W-2:0], 1'b0};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rfd_datapath.sv
module rfd_datapath
  import rfd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW_W-1:0]  ctrl_word,
  input  logic [W-1:0]     data_in,
  output logic [W-1:0]     result_out
);
  ctrl_t                    cw;
  logic [NREG-1:0][W-1:0]   reg_q;
  logic [W-1:0]             bus_a;
  logic [W-1:0]             bus_b;
  logic [W-1:0]             alu_res;

  assign cw = ctrl_t'(ctrl_word);

  rfd_srcmux #(.W(W)) u_mux_a (
    .sel(cw.src_a), .ext(data_in), .regs(reg_q), .operand(bus_a)
  );

  rfd_srcmux #(.W(W)) u_mux_b (
    .sel(cw.src_b), .ext(data_in), .regs(reg_q), .operand(bus_b)
  );

  rfd_alu #(.W(W)) u_alu (
    .func(cw.func), .op_a(bus_a), .op_b(bus_b), .res(alu_res)
  );

  rfd_regfile #(.W(W)) u_rf (
    .clk(clk), .rst_n(rst_n), .dst(cw.dst), .wdata(alu_res), .reg_q(reg_q)
  );

  assign result_out = alu_res;
endmodule

// File: rtl/rfd_datapath_chk.sv
module rfd_datapath_chk
  import rfd_pkg::*;
#(
  parameter int W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CW_W-1:0]         ctrl_word,
  input logic [W-1:0]            data_in,
  input logic [W-1:0]            result_out,
  input logic [NREG-1:0][W-1:0]  regs
);
  logic [SEL_W-1:0]  sa, sb, sd;
  logic [FUNC_W-1:0] fn;
  logic              fn_known;

  always_comb begin
    {sa, sb, sd, fn} = ctrl_word;
    fn_known = fn inside {FN_PASS, FN_INC, FN_ADD, FN_SUB, FN_DEC, FN_AND,
                          FN_OR, FN_XOR, FN_NOT, FN_SHRA, FN_SHL};
  end

  // R3: pass of the input bus reaches the output
  a_r3_input_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (sa == '0 && fn == FN_PASS) |-> result_out == data_in);

  // R5: input minus itself is zero
  a_r5_self_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (sa == '0 && sb == '0 && fn == FN_SUB) |-> result_out == '0);

  // R8: unknown function codes give zero
  a_r8_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fn_known |-> result_out == '0);

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    // R10: the named register holds the result after the edge
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (sd == SEL_W'(k + 1)) |=> regs[k] == $past(result_out));
    // R4: registers not named stay put
    a_r4_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sd != SEL_W'(k + 1)) |=> $stable(regs[k]));
  end
endmodule

bind rfd_datapath rfd_datapath_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .data_in(data_in),
  .result_out(result_out), .regs(reg_q)
);

// File: tb/rfd_datapath_test.sv
`timescale 1ns/1ps
module rfd_datapath_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [13:0]  ctrl_word = '0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] result_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model [1:7];

  always #2.5 clk = ~clk;

  rfd_datapath #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .data_in(data_in), .result_out(result_out)
  );

  function automatic logic [W-1:0] ref_alu(input logic [4:0] f,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (f)
      5'b00000: return a;
      5'b00001: return a + 1;
      5'b00010: return a + b;
      5'b00101: return a - b;
      5'b00110: return a - 1;
      5'b01000: return a & b;
      5'b01010: return a | b;
      5'b01100: return a ^ b;
      5'b01110: return ~a;
      5'b10000: return W'($signed(a) >>> 1);
      5'b10001: return a << 1;
      default:  return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one control word: drive at negedge, check output, model the write
  task automatic step(input string tag, input logic [2:0] a, input logic [2:0] b,
                      input logic [2:0] d, input logic [4:0] f,
                      input logic [W-1:0] din);
    logic [W-1:0] va, vb, e;
    @(negedge clk);
    ctrl_word = {a, b, d, f};
    data_in   = din;
    #1;
    va = (a == 0) ? din : model[a];
    vb = (b == 0) ? din : model[b];
    e  = ref_alu(f, va, vb);
    check(tag, result_out, e);
    if (d != 0) model[d] = e;
  endtask

  task automatic read_all(input string tag);
    for (int k = 1; k <= 7; k++) step(tag, 3'(k), 3'd0, 3'd0, 5'b00000, 8'h00);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int k = 1; k <= 7; k++) model[k] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    read_all("R1 reset value");
  endtask

  task automatic t_load();
    for (int k = 1; k <= 7; k++) step("R4 load", 3'd0, 3'd0, 3'(k), 5'b00000, 8'(8'h13 * k));
    read_all("R3 select A");
    for (int k = 1; k <= 7; k++) step("R3 select B", 3'd0, 3'(k), 3'd0, 5'b00010, 8'h00);
  endtask

  task automatic t_nowrite();
    step("R9 input to output", 3'd0, 3'd0, 3'd0, 5'b00000, 8'hA5);
    step("R9 no dest", 3'd0, 3'd0, 3'd0, 5'b01110, 8'h3C);
    read_all("R4 no dest keeps regs");
  endtask

  task automatic t_arith();
    step("R5 set", 3'd0, 3'd0, 3'd1, 5'b00000, 8'hF0);
    step("R5 set", 3'd0, 3'd0, 3'd2, 5'b00000, 8'h14);
    step("R5 sub", 3'd1, 3'd2, 3'd3, 5'b00101, 8'h00);
    check("R5 sub F0-14", model[3], 8'hDC);
    step("R5 add wrap", 3'd1, 3'd2, 3'd4, 5'b00010, 8'h00);
    step("R5 add input", 3'd2, 3'd0, 3'd0, 5'b00010, 8'h7F);
    step("R5 sub borrow", 3'd2, 3'd1, 3'd0, 5'b00101, 8'h00);
    step("R5 inc wrap", 3'd0, 3'd0, 3'd0, 5'b00001, 8'hFF);
    step("R5 dec wrap", 3'd0, 3'd0, 3'd0, 5'b00110, 8'h00);
    read_all("R5 regs");
  endtask

  task automatic t_logic();
    step("R6 and", 3'd1, 3'd0, 3'd5, 5'b01000, 8'h3C);
    step("R6 or", 3'd2, 3'd0, 3'd0, 5'b01010, 8'hC1);
    step("R6 xor", 3'd1, 3'd2, 3'd0, 5'b01100, 8'h00);
    step("R6 not", 3'd3, 3'd0, 3'd0, 5'b01110, 8'h00);
    step("R6 pass", 3'd5, 3'd0, 3'd0, 5'b00000, 8'h00);
  endtask

  task automatic t_shift();
    step("R7 shra neg", 3'd0, 3'd0, 3'd0, 5'b10000, 8'h90);
    check("R7 shra 90", result_out, 8'hC8);
    step("R7 shra pos", 3'd0, 3'd0, 3'd0, 5'b10000, 8'h41);
    step("R7 shl", 3'd0, 3'd0, 3'd6, 5'b10001, 8'h81);
    check("R7 shl 81", model[6], 8'h02);
  endtask

  task automatic t_undef();
    step("R8 code 00011", 3'd1, 3'd2, 3'd0, 5'b00011, 8'hFF);
    step("R8 code 11111", 3'd1, 3'd2, 3'd7, 5'b11111, 8'hFF);
    step("R8 code 01001", 3'd0, 3'd0, 3'd0, 5'b01001, 8'hFF);
    read_all("R8 zero written");
  endtask

  task automatic t_same();
    step("R10 set R2", 3'd0, 3'd0, 3'd2, 5'b00000, 8'h5A);
    step("R10 xor self", 3'd2, 3'd2, 3'd2, 5'b01100, 8'h00);
    step("R10 R2 cleared", 3'd2, 3'd0, 3'd0, 5'b00000, 8'h00);
    check("R10 R2 zero", result_out, 8'h00);
    step("R10 set R6", 3'd0, 3'd0, 3'd6, 5'b00000, 8'h10);
    step("R10 inc old value", 3'd6, 3'd0, 3'd6, 5'b00001, 8'h00);
    check("R10 inc 10", result_out, 8'h11);
    step("R10 inc again", 3'd6, 3'd0, 3'd6, 5'b00001, 8'h00);
    check("R10 inc 11", result_out, 8'h12);
  endtask

  task automatic t_fields();
    step("R2 fields", 3'd3, 3'd5, 3'd7, 5'b00101, 8'hEE);
    step("R2 fields swap", 3'd5, 3'd3, 3'd1, 5'b00101, 8'hEE);
    read_all("R2 dest field");
  endtask

  initial begin
    t_reset();
    t_load();
    t_nowrite();
    t_arith();
    t_logic();
    t_shift();
    t_undef();
    t_same();
    t_fields();
    @(negedge clk);
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule